// File: doc/BRIEF.md
# LCD Common and Segment Waveform Generator

This block turns a latched set of display bits and a handful of decoded control fields into drive level codes for two common lines and twenty-seven segment lines of a passive LCD panel. Each output line carries a 2-bit level code. Code 00 means ground (VSS), 01 means half supply (MID) and 10 means full supply (VDD). A separate analog stage turns each code into a voltage. Frame timing comes from a counter that advances on an oscillator-enable tick. Five frame lengths can be selected.

Two drive schemes are available. In static drive one common toggles against the segments and the second common stays at ground. In 1/2-duty, 1/2-bias drive the frame is split into quarters so that each common is driven once with each polarity, while the idle common rests at half supply. The lowest pins can instead serve as plain general-purpose outputs. Three overrides act on the outputs, in order of precedence: a display-enable input, a power-save request and a segment blanking request.

Top module: `lcd_wave_gen`

## Requirements
- R1: A frame lasts `mult*UNIT` ticks, where `mult` is taken from `rate_code[2:0]`: 3'b110 gives 8, 3'b111 gives 6, 3'b000 gives 4, 3'b001 gives 3 and 3'b010 gives 2. Every other code gives 4. With the default UNIT=96 the frame lengths are 768, 576, 384, 288 and 192 ticks. The counter is zero after reset and wraps to zero after the last tick of a frame.
- R2: The frame position advances only on clock edges where `osc_tick` is 1. When `osc_tick` is 0 the position holds.
- R3: In static drive (`half_duty`=0), `com1_lvl` is VDD (10) for the first half of the frame and VSS (00) for the second half. `com2_lvl` is VSS throughout.
- R4: In static drive, segment pin n (n=1..27, driven at `seg_lvl[2n-1:2n-2]`) uses `disp_bits[n-1]`. A 1 drives the level opposite to COM1 and a 0 drives the same level as COM1.
- R5: In 1/2-duty drive, the frame has four equal quarters. In them the active common is COM1 at VDD, then COM1 at VSS, then COM2 at VDD, then COM2 at VSS. The idle common is MID (01).
- R6: In 1/2-duty drive, segment pin n uses `disp_bits[2n-2]` during the two COM1 quarters and `disp_bits[2n-1]` during the two COM2 quarters. A 1 drives the level opposite to the active common and a 0 drives the same level.
- R7: `port_sel` values 0 to 4 turn that many pins, counted from pin 1 upward, into general-purpose outputs. Values 5 to 7 act as 4.
- R8: General-purpose pin k (k=1..4) drives VDD when its bit is 1 and VSS when it is 0. The bit is `disp_bits[k-1]` in static drive and `disp_bits[2k-2]` in 1/2-duty drive.
- R9: When `seg_blank`=1, every segment pin that is not a general-purpose output drives the level of the active common. The commons and the general-purpose outputs are unaffected.
- R10: When `pwr_save`=1 (and `show_en`=1), both commons and all segment pins that are not general-purpose outputs drive VSS, and the frame counter is cleared and held at zero. General-purpose outputs keep following their bits.
- R11: When `show_en`=0, every output drives VSS, general-purpose outputs included. The frame counter is cleared and held at zero, and ticks are ignored.
- R12: A change of `rate_code` or `half_duty` restarts the frame at position zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Oscillator-enable tick, one frame-timer step per high cycle |
| show_en | input | 1 | Display enable; low forces every output to VSS |
| half_duty | input | 1 | 0 for static drive, 1 for 1/2-duty drive |
| rate_code | input | 3 | Frame length select |
| port_sel | input | 3 | Number of low pins used as general-purpose outputs |
| seg_blank | input | 1 | Drive off-waveforms on all segment pins |
| pwr_save | input | 1 | Power-save: stop the frame, commons and segments to VSS |
| disp_bits | input | 54 | Display bits |
| com1_lvl | output | 2 | COM1 level code |
| com2_lvl | output | 2 | COM2 level code |
| seg_lvl | output | 54 | Segment level codes, pin n at bits [2n-1:2n-2] |

## Verification
The hardest states to reach are the late quarters of the longest frame and a restart in the middle of a frame. In both, the position inside the frame is invisible at the ports and shows only through which common is active. The stimulus keeps the tick high and counts edges exactly, stepping to the last tick before each quarter and half boundary and to the first tick after it. It then changes the frame length in mid-frame and checks that the new frame starts clean. The port selection is swept through all eight codes in both drive modes. This shows the remapping of port bits between static and 1/2-duty drive.

// File: rtl/lcd_wave_pkg.sv
package lcd_wave_pkg;

    typedef enum logic [1:0] {
        LV_VSS = 2'b00,
        LV_MID = 2'b01,
        LV_VDD = 2'b10
    } level_e;

    typedef enum logic [1:0] {
        PH_A_POS,
        PH_A_NEG,
        PH_B_POS,
        PH_B_NEG
    } phase_e;

    typedef struct packed {
        logic [2:0] rate;
        logic       duty;
    } timing_cfg_t;

    // Frame length in units of UNIT ticks for a given rate code.
    function automatic int unsigned frame_mult(input logic [2:0] code);
        case (code)
            3'b110:  return 8;
            3'b111:  return 6;
            3'b001:  return 3;
            3'b010:  return 2;
            default: return 4;
        endcase
    endfunction

    function automatic level_e flip_level(input level_e lv);
        return (lv == LV_VDD) ? LV_VSS : LV_VDD;
    endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcd_wave_pkg::*;
#(
    parameter int UNIT = 96
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        run,
    input  timing_cfg_t cfg,
    output phase_e      phase
);
    localparam int CW = $clog2(8 * UNIT + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] len;
    logic [CW-1:0] half;
    logic [CW-1:0] qtr;
    timing_cfg_t   cfg_q;
    logic          cfg_chg;

    assign len     = CW'(frame_mult(cfg.rate) * UNIT);
    assign half    = len >> 1;
    assign qtr     = len >> 2;
    assign cfg_chg = (cfg != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            cfg_q <= cfg;
        end else begin
            cfg_q <= cfg;
            if (!run || cfg_chg) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= (cnt == len - CW'(1)) ? '0 : cnt + CW'(1);
            end
        end
    end

    always_comb begin
        if (!cfg.duty) begin
            phase = (cnt < half) ? PH_A_POS : PH_A_NEG;
        end else if (cnt < qtr) begin
            phase = PH_A_POS;
        end else if (cnt < half) begin
            phase = PH_A_NEG;
        end else if (cnt < half + qtr) begin
            phase = PH_B_POS;
        end else begin
            phase = PH_B_NEG;
        end
    end

    // R1: position stays inside the current frame
    a_r1_pos_in_frame: assert property (@(posedge clk) disable iff (rst)
        !cfg_chg |-> (cnt < len));

    // R12: timing change restarts the frame
    a_r12_restart_on_change: assert property (@(posedge clk) disable iff (rst)
        cfg_chg |=> (cnt == '0));

    // R11: stopped timer is cleared
    a_r11_stop_clears: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    // R2: no tick, no movement
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !cfg_chg) |=> $stable(cnt));

endmodule

// File: rtl/lcd_common_drv.sv
module lcd_common_drv
    import lcd_wave_pkg::*;
(
    input  phase_e phase,
    input  logic   duty,
    output level_e com1,
    output level_e com2,
    output level_e active,
    output logic   sel_b
);
    always_comb begin
        active = (phase == PH_A_POS || phase == PH_B_POS) ? LV_VDD : LV_VSS;
        sel_b  = (phase == PH_B_POS || phase == PH_B_NEG);
        if (!duty) begin
            com1 = active;
            com2 = LV_VSS;
        end else begin
            com1 = sel_b ? LV_MID : active;
            com2 = sel_b ? active : LV_MID;
        end
    end
endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
    import lcd_wave_pkg::*;
#(
    parameter int SEG_LINES = 27,
    localparam int DW = 2 * SEG_LINES
) (
    input  logic [DW-1:0] bits,
    input  logic          duty,
    input  logic          sel_b,
    input  level_e        active,
    input  logic          blank,
    output logic [DW-1:0] seg_flat
);
    for (genvar n = 0; n < SEG_LINES; n++) begin : g_pin
        logic bit_on;
        assign bit_on = duty ? bits[2*n + int'(sel_b)] : bits[n];
        assign seg_flat[2*n +: 2] = (bit_on && !blank) ? flip_level(active) : active;
    end
endmodule

// File: rtl/lcd_wave_gen.sv
module lcd_wave_gen
    import lcd_wave_pkg::*;
#(
    parameter int SEG_LINES = 27,
    parameter int PORT_PINS = 4,
    parameter int UNIT      = 96,
    localparam int DW  = 2 * SEG_LINES,
    localparam int PSW = $clog2(PORT_PINS + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           osc_tick,
    input  logic           show_en,
    input  logic           half_duty,
    input  logic [2:0]     rate_code,
    input  logic [PSW-1:0] port_sel,
    input  logic           seg_blank,
    input  logic           pwr_save,
    input  logic [DW-1:0]  disp_bits,
    output logic [1:0]     com1_lvl,
    output logic [1:0]     com2_lvl,
    output logic [DW-1:0]  seg_lvl
);
    timing_cfg_t             cfg;
    logic                    run;
    logic                    tick_g;
    phase_e                  phase;
    level_e                  com1_raw, com2_raw, active;
    logic                    sel_b;
    logic [DW-1:0]           seg_raw;
    logic [PSW-1:0]          port_num;
    logic [PORT_PINS-1:0]    is_port;
    logic [2*PORT_PINS-1:0]  gpo_lvl;

    assign cfg.rate = rate_code;
    assign cfg.duty = half_duty;
    assign run      = show_en && !pwr_save;
    assign tick_g   = osc_tick && show_en;
    assign port_num = (port_sel > PSW'(PORT_PINS)) ? PSW'(PORT_PINS) : port_sel;

    lcd_frame_timer #(.UNIT(UNIT)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_g),
        .run   (run),
        .cfg   (cfg),
        .phase (phase)
    );

    lcd_common_drv u_com (
        .phase  (phase),
        .duty   (half_duty),
        .com1   (com1_raw),
        .com2   (com2_raw),
        .active (active),
        .sel_b  (sel_b)
    );

    lcd_seg_drv #(.SEG_LINES(SEG_LINES)) u_seg (
        .bits     (disp_bits),
        .duty     (half_duty),
        .sel_b    (sel_b),
        .active   (active),
        .blank    (seg_blank),
        .seg_flat (seg_raw)
    );

    for (genvar k = 0; k < PORT_PINS; k++) begin : g_port
        logic port_bit;
        assign is_port[k]         = (PSW'(k) < port_num);
        assign port_bit           = half_duty ? disp_bits[2*k] : disp_bits[k];
        assign gpo_lvl[2*k +: 2]  = port_bit ? LV_VDD : LV_VSS;
    end

    // Override precedence: display enable, then power-save, then blanking.
    always_comb begin
        com1_lvl = com1_raw;
        com2_lvl = com2_raw;
        seg_lvl  = seg_raw;
        if (!run) begin
            com1_lvl = LV_VSS;
            com2_lvl = LV_VSS;
            seg_lvl  = '0;
        end
        for (int k = 0; k < PORT_PINS; k++) begin
            if (is_port[k]) begin
                seg_lvl[2*k +: 2] = show_en ? gpo_lvl[2*k +: 2] : LV_VSS;
            end
        end
    end

    // R3: static drive keeps COM2 at ground
    a_r3_static_com2_low: assert property (@(posedge clk) disable iff (rst)
        !half_duty |-> (com2_lvl == LV_VSS));

    // R11: disabled display is fully dark
    a_r11_disabled_dark: assert property (@(posedge clk) disable iff (rst)
        !show_en |-> (com1_lvl == LV_VSS && com2_lvl == LV_VSS && seg_lvl == '0));

    // R10: power-save grounds both commons
    a_r10_save_commons_low: assert property (@(posedge clk) disable iff (rst)
        (show_en && pwr_save) |-> (com1_lvl == LV_VSS && com2_lvl == LV_VSS));

    // R5: exactly one common idles at mid-level in 1/2 duty
    a_r5_single_idle_common: assert property (@(posedge clk) disable iff (rst)
        (half_duty && run) |-> ($countones({com1_lvl == LV_MID, com2_lvl == LV_MID}) == 1));

    // R9: a blanked segment follows the active common
    a_r9_blank_tracks_common: assert property (@(posedge clk) disable iff (rst)
        (run && seg_blank) |->
        (seg_lvl[DW-1 -: 2] == ((com1_lvl == LV_MID) ? com2_lvl : com1_lvl)));

endmodule

// File: tb/test_lcd_wave_gen.sv
module test_lcd_wave_gen;
    localparam int CLK_PERIOD = 10;
    localparam int SEGS = 27;
    localparam int DW = 2 * SEGS;
    localparam int UNIT = 96;
    localparam logic [1:0] VSS = 2'b00, MID = 2'b01, VDD = 2'b10;

    logic          clk = 1'b0;
    logic          rst;
    logic          osc_tick;
    logic          show_en;
    logic          half_duty;
    logic [2:0]    rate_code;
    logic [2:0]    port_sel;
    logic          seg_blank;
    logic          pwr_save;
    logic [DW-1:0] disp_bits;
    logic [1:0]    com1_lvl, com2_lvl;
    logic [DW-1:0] seg_lvl;

    int compared = 0;
    int mismatched = 0;
    int pos = 0;
    bit chg = 0;
    bit done = 0;

    string           tag_q[$];
    logic [DW+3:0]   val_q[$];
    event            ev_cmp;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_wave_gen i_lcd_wave_gen (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .show_en(show_en),
        .half_duty(half_duty), .rate_code(rate_code), .port_sel(port_sel),
        .seg_blank(seg_blank), .pwr_save(pwr_save), .disp_bits(disp_bits),
        .com1_lvl(com1_lvl), .com2_lvl(com2_lvl), .seg_lvl(seg_lvl)
    );

    function automatic int flen(input logic [2:0] c);
        case (c)
            3'b110:  return 8 * UNIT;
            3'b111:  return 6 * UNIT;
            3'b001:  return 3 * UNIT;
            3'b010:  return 2 * UNIT;
            default: return 4 * UNIT;
        endcase
    endfunction

    function automatic logic [1:0] inv(input logic [1:0] l);
        return (l == VDD) ? VSS : VDD;
    endfunction

    function automatic logic [DW+3:0] model();
        int n, q, np;
        logic [1:0] a, e1, e2;
        logic bsel, b;
        logic [DW-1:0] es;
        n = flen(rate_code);
        bsel = 1'b0;
        if (!half_duty) begin
            a = (pos < n / 2) ? VDD : VSS;
            e1 = a;
            e2 = VSS;
        end else begin
            q = pos / (n / 4);
            bsel = (q >= 2);
            a = (q % 2 == 0) ? VDD : VSS;
            e1 = bsel ? MID : a;
            e2 = bsel ? a : MID;
        end
        for (int p = 0; p < SEGS; p++) begin
            b = half_duty ? disp_bits[2*p + int'(bsel)] : disp_bits[p];
            es[2*p +: 2] = (b && !seg_blank) ? inv(a) : a;
        end
        if (!show_en || pwr_save) begin
            e1 = VSS;
            e2 = VSS;
            es = '0;
        end
        np = (port_sel > 3'd4) ? 4 : int'(port_sel);
        for (int k = 0; k < np; k++) begin
            b = half_duty ? disp_bits[2*k] : disp_bits[k];
            es[2*k +: 2] = (!show_en) ? VSS : (b ? VDD : VSS);
        end
        return {e1, e2, es};
    endfunction

    // Driver side: push the expected item and wake the monitor.
    task automatic expect_now(input string tag);
        tag_q.push_back(tag);
        val_q.push_back(model());
        -> ev_cmp;
        #1;
    endtask

    // Monitor side: pop and compare against the ports.
    initial begin
        forever begin
            @(ev_cmp);
            while (tag_q.size() > 0) begin
                string t;
                logic [DW+3:0] e;
                t = tag_q.pop_front();
                e = val_q.pop_front();
                compared++;
                if ({com1_lvl, com2_lvl, seg_lvl} !== e) begin
                    mismatched++;
                    $display("FAIL %s: actual %h expected %h", t,
                             {com1_lvl, com2_lvl, seg_lvl}, e);
                end
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            if (rst || !show_en || pwr_save || chg) pos = 0;
            else if (osc_tick) pos = (pos == flen(rate_code) - 1) ? 0 : pos + 1;
            chg = 0;
            @(negedge clk);
        end
    endtask

    task automatic set_timing(input logic [2:0] rc, input logic hd);
        if (rc != rate_code || hd != half_duty) chg = 1;
        rate_code = rc;
        half_duty = hd;
        step(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst = 1; osc_tick = 1; show_en = 0; half_duty = 0; rate_code = 3'b000;
        port_sel = 3'd3; seg_blank = 0; pwr_save = 0;
        disp_bits = 54'h2_A5C3_F09E_61B7;
        @(negedge clk);
        step(3);
        rst = 0;
        expect_now("R11 reset dark with ports");

        // static drive, 384-tick frame
        port_sel = 3'd0;
        show_en = 1;
        expect_now("R3 static frame start");
        step(100); expect_now("R4 static mid first half");
        step(91);  expect_now("R3 last tick first half");
        step(1);   expect_now("R3 second half");
        step(192); expect_now("R1 384 wrap");

        osc_tick = 0;
        step(10);  expect_now("R2 tick low holds position");
        osc_tick = 1;
        step(37);  expect_now("R2 resumes");

        // 1/2 duty, longest frame
        set_timing(3'b110, 1'b1); expect_now("R12 restart on duty change");
        step(191); expect_now("R5 end of quarter one");
        step(1);   expect_now("R5 quarter two");
        step(192); expect_now("R6 COM2 positive quarter");
        step(192); expect_now("R6 COM2 negative quarter");
        step(191); expect_now("R1 last tick 768");
        step(1);   expect_now("R1 768 wrap");

        step(50);
        set_timing(3'b111, 1'b1); expect_now("R12 mid-frame restart");
        step(143); expect_now("R1 576 quarter edge before");
        step(1);   expect_now("R1 576 quarter edge");
        set_timing(3'b001, 1'b1);
        step(71);  expect_now("R1 288 quarter edge before");
        step(1);   expect_now("R1 288 quarter edge");
        set_timing(3'b010, 1'b1);
        step(47);  expect_now("R1 192 quarter edge before");
        step(1);   expect_now("R1 192 quarter edge");
        set_timing(3'b011, 1'b0);
        step(191); expect_now("R1 default code before half");
        step(1);   expect_now("R1 default code half");

        // port remapping in both modes
        disp_bits = 54'h1_3C6E_5A90_D24F;
        for (int p = 0; p < 8; p++) begin
            port_sel = 3'(p);
            expect_now("R7 R8 static port select");
        end
        set_timing(3'b010, 1'b1);
        step(100);
        for (int p = 0; p < 8; p++) begin
            port_sel = 3'(p);
            expect_now("R7 R8 duty port select");
        end

        // blanking
        port_sel = 3'd1;
        seg_blank = 1;
        step(10); expect_now("R9 blank with port");
        step(50); expect_now("R9 blank later quarter");
        seg_blank = 0;

        // power-save keeps ports alive
        port_sel = 3'd2;
        pwr_save = 1;
        step(5);  expect_now("R10 power-save ports live");
        pwr_save = 0;
        step(3);  expect_now("R10 resume from zero");

        // display disable beats everything
        port_sel = 3'd4;
        show_en = 0;
        step(5);  expect_now("R11 disabled with ports");
        seg_blank = 1;
        step(5);  expect_now("R11 disabled ignores blank");
        seg_blank = 0;
        show_en = 1;
        step(20); expect_now("R11 restart after enable");

        disp_bits = 54'h3_FFFF_0000_FFFF;
        step(7);  expect_now("R6 new display bits");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule